// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block is the transmit half of a master-mode stereo audio serial port. It takes a left and right PCM sample through a valid/ready handshake, creates its own bit clock from the system clock with a programmable even divider, and shifts the pair out MSB first on one data line while driving a frame sync. The same slot counter and bit selector serve five frame formats: I2S, left-justified, right-justified, and two short-pulse formats (DSP A, where the data starts one bit after the pulse, and DSP B, where the data starts with the pulse).

The bit clock and the frame sync each have their own polarity bit. The polarity bits let the port meet either convention of a downstream codec without changing the frame logic. A "normal" frame sync is defined per format, by the edge that opens the left channel or the frame. The inverted setting gives the complementary waveform. The sample width and the slot width can be set at run time. The data ports, configuration inputs and their encodings are listed below. The configuration is expected to change only while reset is held.

Top module: `aud_ser_tx`

## Requirements
- R1: After reset, and until the first sample pair has been accepted, `bclk` holds the level `bclk_inv`, `fsync` holds its idle level (1 for I2S, 0 for every other format, each XOR `fs_inv`), and `sdata` is 0.
- R2: Once running, `bclk` has a period of `bclk_div` system clocks with equal high and low halves. A frame lasts 2×`slot_w` bit-clock periods, with the left half first and then the right half.
- R3: `sdata` and `fsync` change only on the non-sampling edge of `bclk`. The sampling edge is the rising edge when `bclk_inv`=0 and the falling edge when `bclk_inv`=1.
- R4: I2S (`fmt_sel`=0): under normal frame polarity, `fsync` is low for the left half and high for the right half. Each channel's MSB is sent one bit period after its `fsync` transition. Its `smp_w` bits follow MSB first, and the rest of the slot is 0. When `smp_w`=`slot_w`, the LSB spills into the first bit of the next half.
- R5: Left-justified (`fmt_sel`=1): under normal frame polarity, `fsync` is high for the left half and low for the right half. The MSB is sent in the first bit period of each half, followed by the remaining bits MSB first, and trailing bits are 0.
- R6: Right-justified (`fmt_sel`=2): `fsync` behaves as in R5. The LSB of each channel occupies the last bit period of its half, and the leading `slot_w`-`smp_w` bits are 0.
- R7: DSP A (`fmt_sel`=3): under normal frame polarity, `fsync` is high for only the first bit period of the frame. The left MSB follows one bit period later, and the right sample follows the left LSB directly. All remaining bits are 0.
- R8: DSP B (`fmt_sel`=4): as R7, but the left MSB is sent in the same bit period as the `fsync` pulse.
- R9: With `fs_inv`=1, `fsync` is the exact complement of the `fs_inv`=0 waveform in every format, idle included.
- R10: Samples are taken right-aligned from `in_left`/`in_right` (bit `smp_w`-1 is the MSB). There is a single holding register: `in_ready` is high exactly when it is empty. It is emptied only at a frame start, so at most one pair is accepted per frame.
- R11: If the holding register is empty at a frame start, that frame's data is all zeros and `underrun` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample pair offered |
| in_left | input | WORD_MAX | Left sample, right-aligned |
| in_right | input | WORD_MAX | Right sample, right-aligned |
| in_ready | output | 1 | Holding register empty |
| fmt_sel | input | 3 | 0 I2S, 1 left-justified, 2 right-justified, 3 DSP A, 4 DSP B |
| bclk_inv | input | 1 | 1: data sampled on falling bclk |
| fs_inv | input | 1 | 1: invert frame sync |
| bclk_div | input | DIV_W | System clocks per bit period (even, at least 2) |
| smp_w | input | clog2(WORD_MAX+1) | Sample width in bits, 1..slot_w |
| slot_w | input | clog2(WORD_MAX+1) | Bit periods per channel half, 1..WORD_MAX |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its default parameters: 32-bit words and an 8-bit divider field. The 32-bit word size means full-width 32-bit slots are reachable. There, `smp_w` equals `slot_w`, and the delayed formats carry a right LSB across the frame boundary into bit 0 of the next frame. The divider field covers the smallest divider of 2, where the half period is a single system clock. It also covers larger dividers, so the check of exact bit-clock period and edge placement sees both cases. Narrow samples in wider slots exercise the zero fill at either end of a half.

// File: rtl/aud_tx_pkg.sv
// Shared types for the audio serial transmitter.
// Assumes: the format code is held stable while the port runs.
package aud_tx_pkg;

    typedef enum logic [2:0] {
        FMT_I2S  = 3'd0,
        FMT_LJ   = 3'd1,
        FMT_RJ   = 3'd2,
        FMT_DSPA = 3'd3,
        FMT_DSPB = 3'd4
    } fmt_e;

    // Formats whose data trails the frame-sync edge by one bit period.
    function automatic logic fmt_delayed(fmt_e f);
        return (f == FMT_I2S) || (f == FMT_DSPA);
    endfunction

    // Uninverted frame-sync level before the first frame: opposite of the
    // level the frame opens with, so the first frame shows its start edge.
    function automatic logic fmt_idle_fs(fmt_e f);
        return (f == FMT_I2S);
    endfunction

    function automatic logic fmt_is_dsp(fmt_e f);
        return (f == FMT_DSPA) || (f == FMT_DSPB);
    endfunction

endpackage

// File: rtl/aud_tx_clkgen.sv
// Bit-clock generator. Produces an unpolarised bit clock (raw clock) that
// idles low and, while run is high, toggles every bclk_div/2 system clocks.
// fall_ev marks the system-clock edge on which the raw clock falls; all
// data and frame-sync updates happen there. Assumes bclk_div is even.
module aud_tx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             rclk,
    output logic             fall_ev
);

    logic [DIV_W-1:0] half_w;
    logic [DIV_W-1:0] half_last;
    logic [DIV_W-1:0] cnt;

    // Last count value of a half period (a divider below 2 acts as 2).
    always_comb begin
        half_w    = div >> 1;
        half_last = (half_w == '0) ? '0 : half_w - DIV_W'(1);
    end

    // Half-period counter and raw clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            rclk <= 1'b0;
        end else if (cnt == half_last) begin
            cnt  <= '0;
            rclk <= ~rclk;
        end else begin
            cnt  <= cnt + DIV_W'(1);
        end
    end

    // Falling-edge event of the raw clock.
    assign fall_ev = run && rclk && (cnt == half_last);

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !rclk); // R1
    AST_FALL_LEAVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ev |=> !rclk); // R2

endmodule

// File: rtl/aud_tx_feeder.sv
// Sample intake. One holding register filled through valid/ready, moved to
// the active pair at each frame start. An empty holding register at a frame
// start yields a zero pair and sets the sticky underrun flag.
// Assumes frame_load is a single-cycle pulse.
module aud_tx_feeder #(
    parameter int WORD_MAX = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_MAX-1:0] in_left,
    input  logic [WORD_MAX-1:0] in_right,
    output logic                in_ready,
    input  logic                frame_load,
    output logic                pend_full,
    output logic [WORD_MAX-1:0] act_l,
    output logic [WORD_MAX-1:0] act_r,
    output logic                underrun
);

    logic [WORD_MAX-1:0] pend_l;
    logic [WORD_MAX-1:0] pend_r;
    logic                accept;

    assign in_ready = !pend_full;
    assign accept   = in_valid && in_ready;

    // Holding register: filled on accept, emptied at a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_full <= 1'b0;
            pend_l    <= '0;
            pend_r    <= '0;
        end else if (accept) begin
            pend_full <= 1'b1;
            pend_l    <= in_left;
            pend_r    <= in_right;
        end else if (frame_load) begin
            pend_full <= 1'b0;
        end
    end

    // Active pair and underrun flag, updated at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_l    <= '0;
            act_r    <= '0;
            underrun <= 1'b0;
        end else if (frame_load) begin
            act_l <= pend_full ? pend_l : '0;
            act_r <= pend_full ? pend_r : '0;
            if (!pend_full) underrun <= 1'b1;
        end
    end

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_full && !frame_load |=> pend_full && $stable(pend_l) && $stable(pend_r)); // R10
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R11
    AST_UNDERRUN_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load && !pend_full |=> (act_l == '0) && (act_r == '0) && underrun); // R11

endmodule

// File: rtl/aud_tx_framer.sv
// Frame sequencer. Tracks the bit period within the frame, selects the data
// bit for the chosen format from the active pair, applies the one-period
// delay for the delayed formats, and forms the uninverted frame sync.
// Assumes 1 <= smp_w <= slot_w <= WORD_MAX and a stable configuration.
module aud_tx_framer
    import aud_tx_pkg::*;
#(
    parameter int WORD_MAX = 32,
    localparam int SW_W    = $clog2(WORD_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  fmt_e                fmt,
    input  logic [SW_W-1:0]     smp_w,
    input  logic [SW_W-1:0]     slot_w,
    input  logic                pend_full,
    input  logic [WORD_MAX-1:0] act_l,
    input  logic [WORD_MAX-1:0] act_r,
    input  logic                fall_ev,
    output logic                running,
    output logic                frame_load,
    output logic                fs_raw,
    output logic                sd_raw
);

    localparam int PW = $clog2(2 * WORD_MAX);
    localparam int AW = PW + 1;
    localparam int IX = $clog2(WORD_MAX);

    logic [PW-1:0]       pos;
    logic                dly_q;
    logic [AW-1:0]       e_pos, e_slot, e_smp, last;
    logic [AW-1:0]       q;
    logic                in_right;
    logic [WORD_MAX-1:0] word;
    logic                base;
    logic                fs_run;
    logic                start;
    logic                frame_end;

    // Position arithmetic in a common width.
    always_comb begin
        e_pos     = AW'(pos);
        e_slot    = AW'(slot_w);
        e_smp     = AW'(smp_w);
        last      = (e_slot << 1) - AW'(1);
        in_right  = (e_pos >= e_slot);
        q         = in_right ? (e_pos - e_slot) : e_pos;
        word      = in_right ? act_r : act_l;
        frame_end = (e_pos == last);
    end

    // Undelayed data bit of the current bit period for the selected format.
    always_comb begin
        base = 1'b0;
        unique case (fmt)
            FMT_I2S, FMT_LJ: begin
                if (q < e_smp) base = word[IX'(e_smp - AW'(1) - q)];
            end
            FMT_RJ: begin
                if (q >= e_slot - e_smp) base = word[IX'(e_slot - AW'(1) - q)];
            end
            FMT_DSPA, FMT_DSPB: begin
                if (e_pos < e_smp)
                    base = act_l[IX'(e_smp - AW'(1) - e_pos)];
                else if (e_pos < (e_smp << 1))
                    base = act_r[IX'((e_smp << 1) - AW'(1) - e_pos)];
            end
            default: base = 1'b0;
        endcase
    end

    // Uninverted frame-sync level while running.
    always_comb begin
        unique case (fmt)
            FMT_I2S:            fs_run = in_right;
            FMT_LJ, FMT_RJ:     fs_run = !in_right;
            FMT_DSPA, FMT_DSPB: fs_run = (e_pos == '0);
            default:            fs_run = 1'b0;
        endcase
    end

    assign start      = !running && pend_full;
    assign frame_load = start || (fall_ev && frame_end);
    assign fs_raw     = running ? fs_run : fmt_idle_fs(fmt);
    assign sd_raw     = running ? (fmt_delayed(fmt) ? dly_q : base) : 1'b0;

    // Run state, bit position and one-period data delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pos     <= '0;
            dly_q   <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
            pos     <= '0;
        end else if (fall_ev) begin
            dly_q <= base;
            pos   <= frame_end ? '0 : pos + PW'(1);
        end
    end

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (e_pos <= last)); // R2
    AST_DSP_PULSE_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        running && fmt_is_dsp(fmt) && fs_raw && fall_ev |=> !fs_raw); // R7
    AST_STAYS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running); // R1

endmodule

// File: rtl/aud_ser_tx.sv
// Multi-format audio serial transmitter, master mode, two channels.
// Joins the bit-clock generator, the sample intake and the frame sequencer,
// and applies the two output polarities. The raw clock always carries the
// data change on its falling edge, so XOR with bclk_inv moves the sampling
// edge to falling bclk when inverted. Assumes configuration changes only
// during reset.
module aud_ser_tx
    import aud_tx_pkg::*;
#(
    parameter int  WORD_MAX = 32,
    parameter int  DIV_W    = 8,
    localparam int SW_W     = $clog2(WORD_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_MAX-1:0] in_left,
    input  logic [WORD_MAX-1:0] in_right,
    output logic                in_ready,
    input  logic [2:0]          fmt_sel,
    input  logic                bclk_inv,
    input  logic                fs_inv,
    input  logic [DIV_W-1:0]    bclk_div,
    input  logic [SW_W-1:0]     smp_w,
    input  logic [SW_W-1:0]     slot_w,
    output logic                bclk,
    output logic                fsync,
    output logic                sdata,
    output logic                underrun
);

    fmt_e                fmt;
    logic                rclk;
    logic                fall_ev;
    logic                running;
    logic                frame_load;
    logic                pend_full;
    logic [WORD_MAX-1:0] act_l;
    logic [WORD_MAX-1:0] act_r;
    logic                fs_raw;
    logic                sd_raw;

    assign fmt = fmt_e'(fmt_sel);

    aud_tx_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .div     (bclk_div),
        .rclk    (rclk),
        .fall_ev (fall_ev)
    );

    aud_tx_feeder #(.WORD_MAX(WORD_MAX)) feeder_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_left    (in_left),
        .in_right   (in_right),
        .in_ready   (in_ready),
        .frame_load (frame_load),
        .pend_full  (pend_full),
        .act_l      (act_l),
        .act_r      (act_r),
        .underrun   (underrun)
    );

    aud_tx_framer #(.WORD_MAX(WORD_MAX)) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .smp_w      (smp_w),
        .slot_w     (slot_w),
        .pend_full  (pend_full),
        .act_l      (act_l),
        .act_r      (act_r),
        .fall_ev    (fall_ev),
        .running    (running),
        .frame_load (frame_load),
        .fs_raw     (fs_raw),
        .sd_raw     (sd_raw)
    );

    // Output polarity.
    assign bclk  = rclk ^ bclk_inv;
    assign fsync = fs_raw ^ fs_inv;
    assign sdata = sd_raw;

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata != $past(sdata)) |-> !rclk); // R3
    AST_SYNC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync != $past(fsync)) |-> !rclk); // R3
    AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !sdata && (bclk == bclk_inv)); // R1

endmodule

// File: tb/aud_ser_tx_tb.sv
`timescale 1ns/1ps
module aud_ser_tx_tb_top;

    localparam int WM   = 32;
    localparam int DW   = 8;
    localparam int SW_W = $clog2(WM + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [WM-1:0]   in_left = '0;
    logic [WM-1:0]   in_right = '0;
    logic            in_ready;
    logic [2:0]      fmt_sel = 3'd0;
    logic            bclk_inv = 1'b0;
    logic            fs_inv = 1'b0;
    logic [DW-1:0]   bclk_div = DW'(4);
    logic [SW_W-1:0] smp_w = SW_W'(16);
    logic [SW_W-1:0] slot_w = SW_W'(16);
    logic            bclk, fsync, sdata, underrun;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] ls [8];
    logic [31:0] rs [8];
    bit cap_fs [1024];
    bit cap_sd [1024];
    int gap_bad;
    int chg_bad;

    always #2 clk = ~clk;

    aud_ser_tx #(.WORD_MAX(WM), .DIV_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .in_ready(in_ready), .fmt_sel(fmt_sel),
        .bclk_inv(bclk_inv), .fs_inv(fs_inv), .bclk_div(bclk_div),
        .smp_w(smp_w), .slot_w(slot_w), .bclk(bclk), .fsync(fsync),
        .sdata(sdata), .underrun(underrun)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string fmt_tag(int f);
        case (f)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic do_reset(int f, bit bi, bit fi, int div, int smp, int slw);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        fmt_sel  = 3'(f);
        bclk_inv = bi;
        fs_inv   = fi;
        bclk_div = DW'(div);
        smp_w    = SW_W'(smp);
        slot_w   = SW_W'(slw);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_left  = ls[i];
            in_right = rs[i];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic capture(int n, bit bi, int div);
        bit pb, psd, pfs;
        int k = 0;
        int since = 0;
        bit first = 1'b1;
        gap_bad = 0;
        chg_bad = 0;
        @(negedge clk);
        pb = bclk; psd = sdata; pfs = fsync;
        while (k < n) begin
            @(negedge clk);
            since++;
            if ((sdata != psd || fsync != pfs) && (bclk != bi)) chg_bad++;
            if (bi ? (pb && !bclk) : (!pb && bclk)) begin
                if (!first && since != div) gap_bad++;
                first = 1'b0;
                since = 0;
                cap_fs[k] = fsync;
                cap_sd[k] = sdata;
                k++;
            end
            pb = bclk; psd = sdata; pfs = fsync;
        end
    endtask

    function automatic bit exp_base(int f, int fr, int p, int smp, int slw, int np);
        logic [31:0] l, r, w;
        bit right;
        int q;
        l = (fr < np) ? ls[fr] : 32'd0;
        r = (fr < np) ? rs[fr] : 32'd0;
        right = (p >= slw);
        q = right ? p - slw : p;
        w = right ? r : l;
        case (f)
            0, 1: return (q < smp) ? w[smp-1-q] : 1'b0;
            2:    return (q >= slw - smp) ? w[slw-1-q] : 1'b0;
            default: begin
                if (p < smp) return l[smp-1-p];
                if (p < 2*smp) return r[2*smp-1-p];
                return 1'b0;
            end
        endcase
    endfunction

    function automatic bit exp_sd(int f, int fr, int p, int smp, int slw, int np);
        if (f == 0 || f == 3) begin
            if (p == 0) return (fr == 0) ? 1'b0 : exp_base(f, fr-1, 2*slw-1, smp, slw, np);
            return exp_base(f, fr, p-1, smp, slw, np);
        end
        return exp_base(f, fr, p, smp, slw, np);
    endfunction

    function automatic bit exp_fs(int f, int p, int slw, bit fi);
        bit v;
        case (f)
            0:       v = (p >= slw);
            1, 2:    v = (p < slw);
            default: v = (p == 0);
        endcase
        return v ^ fi;
    endfunction

    // One frame-format scenario: push np pairs, capture nf frames, compare.
    task automatic run_case(int f, bit bi, bit fi, int div, int smp, int slw, int np, int nf);
        logic [31:0] mask;
        int n, bad_fs, bad_sd, a_fs, e_fs, a_sd, e_sd;
        mask = (smp == 32) ? 32'hFFFF_FFFF : ((32'd1 << smp) - 32'd1);
        for (int i = 0; i < 8; i++) begin
            ls[i] = (32'h9E37_79B9 * (i + 1) + 32'(f)) & mask;
            rs[i] = (32'h7F4A_7C15 ^ (32'h0101_0101 * i + 32'(div))) & mask;
        end
        do_reset(f, bi, fi, div, smp, slw);
        n = nf * 2 * slw;
        fork
            push(np);
            capture(n, bi, div);
        join
        bad_fs = 0; bad_sd = 0; a_fs = 0; e_fs = 0; a_sd = 0; e_sd = 0;
        for (int e = 0; e < n; e++) begin
            int fr = e / (2 * slw);
            int p  = e % (2 * slw);
            bit xf = exp_fs(f, p, slw, fi);
            bit xd = exp_sd(f, fr, p, smp, slw, np);
            if (cap_fs[e] != xf) begin
                if (bad_fs == 0) begin a_fs = cap_fs[e]; e_fs = xf; end
                bad_fs++;
            end
            if (cap_sd[e] != xd) begin
                if (bad_sd == 0) begin a_sd = cap_sd[e]; e_sd = xd; end
                bad_sd++;
            end
        end
        chk(bad_fs == 0, fi ? "R9" : fmt_tag(f), "fsync waveform (first bad bit)", a_fs, e_fs);
        chk(bad_sd == 0, (nf > np) ? "R11" : fmt_tag(f), "serial data (first bad bit)", a_sd, e_sd);
        chk(gap_bad == 0, "R2", "bclk periods off divider", gap_bad, 0);
        chk(chg_bad == 0, "R3", "changes on sampling phase", chg_bad, 0);
        chk(underrun == (nf > np), "R11", "underrun flag", int'(underrun), int'(nf > np));
    endtask

    // Idle state after reset for two polarity/format settings.
    task automatic test_idle();
        int moves = 0;
        bit b0;
        do_reset(0, 1'b1, 1'b0, 4, 16, 16);
        @(negedge clk);
        chk(bclk == 1'b1, "R1", "idle bclk, inverted", int'(bclk), 1);
        chk(fsync == 1'b1, "R1", "idle fsync I2S", int'(fsync), 1);
        chk(sdata == 1'b0, "R1", "idle sdata", int'(sdata), 0);
        chk(in_ready == 1'b1, "R10", "ready after reset", int'(in_ready), 1);
        chk(underrun == 1'b0, "R11", "underrun after reset", int'(underrun), 0);
        b0 = bclk;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bclk != b0) moves++;
        end
        chk(moves == 0, "R1", "bclk toggles before data", moves, 0);
        do_reset(1, 1'b0, 1'b1, 4, 16, 16);
        @(negedge clk);
        chk(bclk == 1'b0, "R1", "idle bclk, normal", int'(bclk), 0);
        chk(fsync == 1'b1, "R9", "idle fsync LJ inverted", int'(fsync), 1);
    endtask

    // Holding register: full after two pushes until the second frame starts.
    task automatic test_hold();
        for (int i = 0; i < 8; i++) begin
            ls[i] = 32'(i + 1);
            rs[i] = 32'(i + 9);
        end
        do_reset(1, 1'b0, 1'b0, 4, 16, 16);
        push(2);
        chk(in_ready == 1'b0, "R10", "ready with pair held", int'(in_ready), 0);
        repeat (118) @(negedge clk);
        chk(in_ready == 1'b0, "R10", "ready before frame end", int'(in_ready), 0);
        repeat (12) @(negedge clk);
        chk(in_ready == 1'b1, "R10", "ready after second frame start", int'(in_ready), 1);
        chk(underrun == 1'b0, "R11", "no underrun while fed", int'(underrun), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        test_idle();
        run_case(0, 1'b0, 1'b0, 4, 16, 16, 2, 3);   // R4, underrun in frame 3
        run_case(0, 1'b1, 1'b1, 2, 8, 8, 2, 2);     // R4, R9
        run_case(1, 1'b0, 1'b1, 6, 12, 16, 2, 2);   // R5, R9
        run_case(2, 1'b1, 1'b0, 4, 12, 16, 2, 2);   // R6
        run_case(3, 1'b0, 1'b0, 4, 16, 16, 2, 2);   // R7
        run_case(4, 1'b1, 1'b1, 2, 10, 12, 2, 2);   // R8, R9
        run_case(0, 1'b0, 1'b0, 2, 32, 32, 3, 4);   // R4 full width, R11
        run_case(3, 1'b1, 1'b0, 2, 32, 32, 2, 2);   // R7 full width
        test_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule